// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a slave-only control port for a two-wire serial bus. It sits behind an open-drain bus pad. The serial clock comes in as an input only. The data line is read through one input and pulled low through an output enable. Both lines are brought into the system clock domain and oversampled there. The block watches for START and STOP conditions, collects bytes, and answers a single fixed 7-bit device address, `0101101`. Through that address it reads and writes a parameterised bank of 8-bit registers, and all registers are cleared at reset.

A write transfer sends three bytes: the device address with the direction bit clear, a register pointer, and one data byte. A read first loads the pointer in the same way. The master then issues a repeated START and sends the device address with the direction bit set. The block shifts out the addressed register, MSB first, and the master ends the byte with a not-acknowledge. The pointer is kept between transfers. Pointers that lie outside the bank are still acknowledged, but writes to them are dropped and reads from them return zero.

Top module: `twi_reg_slave`

## Requirements
- R1: A byte whose upper seven bits equal `0101101` is acknowledged. The block pulls SDA low for the whole ninth clock pulse. A direction bit (bit 0) of 0 selects write and 1 selects read.
- R2: A write transfer is address+W, then the register pointer, then one data byte. Each byte is acknowledged, and the data byte is stored at the pointer.
- R3: A combined read is a pointer write, a repeated START, and then address+R. The block drives the register at the pointer MSB first, one bit for each SCL pulse. It releases SDA after the eighth bit and leaves it released after the master's not-acknowledge.
- R4: A device address other than `0101101` is not acknowledged. Until the next STOP, no byte is acknowledged and no register changes, and this holds even if a START occurs in that time.
- R5: A STOP in the middle of a data byte ends the transfer with no register written.
- R6: A START in the middle of a byte discards the partial byte and begins a fresh device-address phase, which then proceeds normally.
- R7: Only one data byte is accepted per write transfer. A second data byte is not acknowledged and is written nowhere.
- R8: The register pointer is kept across transfers. A read that begins directly with address+R returns the register that was last addressed.
- R9: With `NUM_REGS` = 16, pointers 0x10 to 0xFF are acknowledged. Writes to them are discarded and reads from them return 0x00.
- R10: After reset, SDA is released and every register reads 0x00.
- R11: The block starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock from the bus pad |
| sdaIn | input | 1 | Serial data as seen on the bus pad |
| sdaOe | output | 1 | When 1, the pad pulls SDA low |

## Verification
The hardest states to reach are the abort paths. These include a STOP or a repeated START that arrives after only a few bits of a byte, and a START that appears while the block is ignoring a foreign address. The bench reaches them with a bit-level master. That master can emit any number of bits and then form a START or STOP from a low-SCL position. Every effect is then read back through normal combined reads. A monitor on the enable output flags any case where the slave starts driving SDA while SCL is high.

// File: rtl/twi_reg_pkg.sv
package twi_reg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_DEVACK,
    ST_REGADDR,
    ST_REGACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_HOLD,
    ST_WAITSTOP
  } ctrl_state_t;

  // Bus conditions seen by the datapath, one cycle pulses
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
  } bus_event_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capPtr;
    logic wrReg;
    logic loadTx;
    logic shiftTx;
    logic ackOn;
    logic txOn;
  } ctrl_strobe_t;

endpackage

// File: rtl/twi_reg_dp.sv
module twi_reg_dp
  import twi_reg_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  ctrl_strobe_t strb,
  output bus_event_t   ev,
  output logic [7:0]   rxByte,
  output logic         sdaOe
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic [7:0] ptr;
  logic [7:0] txByte;
  logic [7:0] bank [NUM_REGS];
  logic [7:0] readVal;
  logic       inRange;

  // Synchronizers, reset to the idle-high bus level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  assign ev.sclRise   = sclS & ~sclD;
  assign ev.sclFall   = ~sclS & sclD;
  assign ev.startSeen = sclS & sclD & sdaD & ~sdaS;
  assign ev.stopSeen  = sclS & sclD & ~sdaD & sdaS;

  // Receive shifter: data is captured when SCL goes high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rxByte <= 8'h00;
    else if (ev.sclRise) rxByte <= {rxByte[6:0], sdaS};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ptr <= 8'h00;
    else if (strb.capPtr) ptr <= rxByte;
  end

  assign inRange = int'(ptr) < NUM_REGS;

  // Register bank, one flop group per entry
  for (genvar g = 0; g < NUM_REGS; g++) begin : gBank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bank[g] <= 8'h00;
      else if (strb.wrReg && inRange && ptr[IDX_W-1:0] == IDX_W'(g))
        bank[g] <= rxByte;
    end
  end

  assign readVal = inRange ? bank[ptr[IDX_W-1:0]] : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txByte <= 8'hFF;
    else if (strb.loadTx)  txByte <= readVal;
    else if (strb.shiftTx) txByte <= {txByte[6:0], 1'b1};
  end

  // Registered pad enable, glitch-free
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdaOe <= 1'b0;
    else       sdaOe <= strb.ackOn | (strb.txOn & ~txByte[7]);
  end

  a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclS)
    else $error("R11: SDA pulled low while SCL high");

  a_r2_write_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrReg |-> ev.sclFall)
    else $error("R2: register write outside an SCL fall");

  a_r9_out_of_range_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadTx && !inRange) |=> txByte == 8'h00)
    else $error("R9: out-of-range read not zero");

endmodule

// File: rtl/twi_reg_ctrl.sv
module twi_reg_ctrl
  import twi_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0101101
) (
  input  logic         clk,
  input  logic         rstN,
  input  bus_event_t   ev,
  input  logic [7:0]   rxByte,
  output ctrl_strobe_t strb,
  output ctrl_state_t  state
);

  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);

  ctrl_state_t      stNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic             rdFlag, rdNext;
  logic             byteDone;

  assign byteDone = ev.sclFall && (bitCnt == LAST_BIT);

  always_comb begin
    stNext       = state;
    cntNext      = bitCnt;
    rdNext       = rdFlag;
    strb         = '0;
    strb.ackOn   = (state == ST_DEVACK) || (state == ST_REGACK) || (state == ST_WACK);
    strb.txOn    = (state == ST_RDATA);
    if (ev.stopSeen) begin
      stNext  = ST_IDLE;
      cntNext = '0;
    end else if (ev.startSeen && state != ST_WAITSTOP) begin
      stNext  = ST_DEVADDR;
      cntNext = '0;
    end else begin
      unique case (state)
        ST_DEVADDR, ST_REGADDR, ST_WDATA: begin
          if (ev.sclRise) cntNext = bitCnt + 1'b1;
          if (byteDone) begin
            cntNext = '0;
            if (state == ST_DEVADDR) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                stNext = ST_DEVACK;
                rdNext = rxByte[0];
              end else begin
                stNext = ST_WAITSTOP;
              end
            end else if (state == ST_REGADDR) begin
              strb.capPtr = 1'b1;
              stNext      = ST_REGACK;
            end else begin
              strb.wrReg = 1'b1;
              stNext     = ST_WACK;
            end
          end
        end
        ST_DEVACK: if (ev.sclFall) begin
          if (rdFlag) begin
            strb.loadTx = 1'b1;
            stNext      = ST_RDATA;
          end else begin
            stNext = ST_REGADDR;
          end
        end
        ST_REGACK: if (ev.sclFall) stNext = ST_WDATA;
        ST_WACK:   if (ev.sclFall) stNext = ST_HOLD;
        ST_RDATA: begin
          if (ev.sclRise) cntNext = bitCnt + 1'b1;
          if (byteDone) begin
            cntNext = '0;
            stNext  = ST_RACK;
          end else if (ev.sclFall) begin
            strb.shiftTx = 1'b1;
          end
        end
        ST_RACK:  if (ev.sclFall) stNext = ST_HOLD;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      rdFlag <= 1'b0;
    end else begin
      state  <= stNext;
      bitCnt <= cntNext;
      rdFlag <= rdNext;
    end
  end

  // Checker state: one data write per transfer
  logic wroteFlag;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           wroteFlag <= 1'b0;
    else if (ev.startSeen || ev.stopSeen) wroteFlag <= 1'b0;
    else if (strb.wrReg)                  wroteFlag <= 1'b1;
  end

  a_r7_one_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrReg |-> !wroteFlag)
    else $error("R7: second write in one transfer");

  a_r1_ack_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEVACK && $past(state) != ST_DEVACK) |-> $past(ev.sclFall))
    else $error("R1: address ack entered off an SCL fall");

endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
  import twi_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0101101,
  parameter int         NUM_REGS = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  bus_event_t   ev;
  ctrl_strobe_t strb;
  ctrl_state_t  state;
  logic [7:0]   rxByte;

  twi_reg_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte),
    .strb(strb), .state(state)
  );

  twi_reg_dp #(.NUM_REGS(NUM_REGS), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strb(strb), .ev(ev), .rxByte(rxByte), .sdaOe(sdaOe)
  );

  a_r4_silent_on_mismatch: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITSTOP && $past(state) == ST_WAITSTOP) |-> !sdaOe)
    else $error("R4: SDA driven after address mismatch");

  a_r10_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state) == ST_IDLE) |-> !sdaOe)
    else $error("R10: SDA driven while idle");

endmodule

// File: tb/twi_reg_slave_bench.sv
`timescale 1ns/1ps
module twi_reg_slave_bench;

  localparam int Q   = 10;
  localparam int GAP = 140;
  localparam logic [7:0] ADDR_W = 8'h5A;
  localparam logic [7:0] ADDR_R = 8'h5B;

  // {pointer, data, expected read-back}
  localparam logic [23:0] VEC [8] = '{
    {8'h00, 8'hA5, 8'hA5},
    {8'h0F, 8'h5A, 8'h5A},
    {8'h07, 8'hFF, 8'hFF},
    {8'h01, 8'h00, 8'h00},
    {8'h10, 8'h99, 8'h00},
    {8'hFF, 8'h3C, 8'h00},
    {8'h02, 8'h81, 8'h81},
    {8'h0E, 8'h7E, 8'h7E}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  wire  sdaLine = sdaM & ~sdaOe;

  int checks = 0;
  int fails = 0;
  int r11Bad = 0;
  logic prevOe = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  twi_reg_slave u_twi_reg_slave (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaOe(sdaOe)
  );

  // R11 monitor: the slave may only begin driving while SCL is low
  always @(negedge clk) begin
    if (rstN && sdaOe && !prevOe && scl) r11Bad++;
    prevOe <= sdaOe;
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; scl = 1'b1; idle(Q);
    sdaM = 1'b0; idle(Q);
    scl = 1'b0; idle(Q);
  endtask

  task automatic repStart();
    sdaM = 1'b1; idle(Q);
    scl = 1'b1; idle(Q);
    sdaM = 1'b0; idle(Q);
    scl = 1'b0; idle(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; idle(Q);
    scl = 1'b1; idle(Q);
    sdaM = 1'b1; idle(GAP);
  endtask

  task automatic sendBit(logic b);
    sdaM = b; idle(Q);
    scl = 1'b1; idle(2 * Q);
    scl = 1'b0; idle(Q);
  endtask

  task automatic sendByte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; idle(Q);
    scl = 1'b1; idle(Q);
    ack = ~sdaLine;
    idle(Q);
    scl = 1'b0; idle(Q);
  endtask

  task automatic recvByte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; idle(Q);
      scl = 1'b1; idle(Q);
      b[i] = sdaLine;
      idle(Q);
      scl = 1'b0; idle(Q);
    end
    sendBit(1'b1); // master NACK
  endtask

  task automatic writeReg(logic [7:0] p, logic [7:0] d);
    logic ack;
    busStart();
    sendByte(ADDR_W, ack); chk(ack, "R1 addr ack", 8'(ack), 8'd1);
    sendByte(p, ack);      chk(ack, "R2 ptr ack", 8'(ack), 8'd1);
    sendByte(d, ack);      chk(ack, "R2 data ack", 8'(ack), 8'd1);
    busStop();
  endtask

  task automatic readReg(logic [7:0] p, output logic [7:0] d);
    logic ack;
    busStart();
    sendByte(ADDR_W, ack); chk(ack, "R3 addr ack", 8'(ack), 8'd1);
    sendByte(p, ack);      chk(ack, "R3 ptr ack", 8'(ack), 8'd1);
    repStart();
    sendByte(ADDR_R, ack); chk(ack, "R3 read ack", 8'(ack), 8'd1);
    recvByte(d);
    busStop();
  endtask

  initial begin
    logic [7:0] rd;
    logic ack;
    idle(5);
    rstN = 1'b1;
    idle(20);

    // R10 reset state
    chk(sdaOe == 1'b0, "R10 released", 8'(sdaOe), 8'd0);
    readReg(8'h03, rd); chk(rd == 8'h00, "R10 reg3 zero", rd, 8'h00);
    readReg(8'h0F, rd); chk(rd == 8'h00, "R10 reg15 zero", rd, 8'h00);

    // Vector table: R2 write, R3 read back, R9 out of range
    for (int v = 0; v < 8; v++) begin
      writeReg(VEC[v][23:16], VEC[v][15:8]);
      readReg(VEC[v][23:16], rd);
      chk(rd == VEC[v][7:0], "R2/R3/R9 table", rd, VEC[v][7:0]);
      chk(sdaOe == 1'b0, "R3 released after read", 8'(sdaOe), 8'd0);
    end

    // R4 foreign address, START inside ignored window
    busStart();
    sendByte(8'h5C, ack); chk(!ack, "R4 foreign addr", 8'(ack), 8'd0);
    sendByte(8'h03, ack); chk(!ack, "R4 byte2", 8'(ack), 8'd0);
    repStart();
    sendByte(ADDR_W, ack); chk(!ack, "R4 start ignored", 8'(ack), 8'd0);
    sendByte(8'h03, ack);
    sendByte(8'h77, ack);  chk(!ack, "R4 data ignored", 8'(ack), 8'd0);
    busStop();
    readReg(8'h03, rd); chk(rd == 8'h00, "R4 reg3 unchanged", rd, 8'h00);

    // R5 STOP mid data byte
    writeReg(8'h04, 8'h11);
    busStart();
    sendByte(ADDR_W, ack);
    sendByte(8'h04, ack);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    busStop();
    readReg(8'h04, rd); chk(rd == 8'h11, "R5 stop abort", rd, 8'h11);

    // R6 START mid byte, then a clean write
    busStart();
    sendByte(ADDR_W, ack);
    sendByte(8'h05, ack);
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b0);
    repStart();
    sendByte(ADDR_W, ack); chk(ack, "R6 new addr ack", 8'(ack), 8'd1);
    sendByte(8'h06, ack);  chk(ack, "R6 ptr ack", 8'(ack), 8'd1);
    sendByte(8'h66, ack);  chk(ack, "R6 data ack", 8'(ack), 8'd1);
    busStop();
    readReg(8'h05, rd); chk(rd == 8'h00, "R6 reg5 untouched", rd, 8'h00);
    readReg(8'h06, rd); chk(rd == 8'h66, "R6 reg6 written", rd, 8'h66);

    // R7 second data byte refused
    busStart();
    sendByte(ADDR_W, ack);
    sendByte(8'h08, ack);
    sendByte(8'h81, ack);  chk(ack, "R7 first data ack", 8'(ack), 8'd1);
    sendByte(8'h82, ack);  chk(!ack, "R7 second data nack", 8'(ack), 8'd0);
    busStop();
    readReg(8'h08, rd); chk(rd == 8'h81, "R7 reg8", rd, 8'h81);
    readReg(8'h09, rd); chk(rd == 8'h00, "R7 reg9", rd, 8'h00);

    // R8 pointer retained
    writeReg(8'h0A, 8'h3C);
    busStart();
    sendByte(ADDR_R, ack); chk(ack, "R8 read ack", 8'(ack), 8'd1);
    recvByte(rd);
    busStop();
    chk(rd == 8'h3C, "R8 kept pointer", rd, 8'h3C);

    // R9 out-of-range pointer acknowledged
    busStart();
    sendByte(ADDR_W, ack);
    sendByte(8'h80, ack); chk(ack, "R9 ptr ack", 8'(ack), 8'd1);
    sendByte(8'h12, ack); chk(ack, "R9 data ack", 8'(ack), 8'd1);
    busStop();
    readReg(8'h00, rd); chk(rd == 8'hA5, "R9 no alias to reg0", rd, 8'hA5);

    chk(r11Bad == 0, "R11 drive timing", 8'(r11Bad), 8'd0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule